// File: doc/BRIEF.md
# Pipelined Dual-Bank FIR Multiply-Accumulate Engine

This block computes one FIR filter output: the sum of N products of a coefficient and a sample. Coefficients are stored in one synchronous memory and samples in a second, separate one. Each memory has its own read port and its own address pointer with a private incrementer. Because of this, both operands of a tap are addressed in the same cycle and arrive together, with no arbitration between them.

Each tap moves through three stages. In the first stage both pointers present addresses and then advance. In the second stage the memories return data, one cycle later. In the third stage the 16x16 signed product is added into a 40-bit accumulator. The stages overlap, so one tap completes every clock. A sum of N taps takes N+2 cycles from the start pulse.

To use the block, pulse `start_i` together with a tap count, two base addresses and an overflow mode. Then wait for the single-cycle `valid_o` pulse. Filling the sample buffer and sequencing successive outputs belong to the surrounding logic.

Top module: `fir_mac_engine`

## Requirements
- R1: After reset, `valid_o`, `busy_o`, `coef_re_o` and `samp_re_o` are low and `result_o` is zero.
- R2: With tap count N, the result equals the sum over i = 0..N-1 of coef[(coef_base+i) mod 2^ADDR_W] times samp[(samp_base+i) mod 2^ADDR_W]. Both operands are 16-bit two's complement.
- R3: Both read enables are high in exactly the same cycles. On the k-th read cycle (k from 0), the coefficient address is coef_base+k and the sample address is samp_base+k, wrapping modulo 2^ADDR_W.
- R4: If `start_i` is accepted in cycle s and N > 0, reads occur in the consecutive cycles s+1..s+N, one tap per cycle. `valid_o` is high for exactly one cycle, in cycle s+N+2.
- R5: For N > 0, `busy_o` is high in cycles s+1..s+N+1. A `start_i` pulse while `busy_o` is high is ignored: it changes neither the timing nor the result of the running sum.
- R6: A tap count of zero issues no reads, keeps `busy_o` low, and gives `valid_o` in cycle s+1 with a zero result.
- R7: The accumulator is cleared on every accepted start, so earlier sums never leak into a new result.
- R8: With `sat_en_i` = 1 at start, each accumulate step clamps to the range [-2^39, 2^39-1].
- R9: With `sat_en_i` = 0 at start, the accumulator wraps in 40-bit two's complement.
- R10: `result_o` keeps the final sum after `valid_o` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a new sum; taken only when not busy |
| taps_i | input | CNT_W (10) | Number of taps N, sampled at start |
| coef_base_i | input | ADDR_W (10) | First coefficient address |
| samp_base_i | input | ADDR_W (10) | First sample address |
| sat_en_i | input | 1 | 1 = saturating accumulate, 0 = wrapping; sampled at start |
| coef_re_o | output | 1 | Coefficient memory read enable |
| coef_addr_o | output | ADDR_W (10) | Coefficient memory address |
| coef_rdata_i | input | DATA_W (16) | Coefficient read data, one cycle after the address |
| samp_re_o | output | 1 | Sample memory read enable |
| samp_addr_o | output | ADDR_W (10) | Sample memory address |
| samp_rdata_i | input | DATA_W (16) | Sample read data, one cycle after the address |
| busy_o | output | 1 | Sum in progress |
| valid_o | output | 1 | One-cycle pulse marking the final sum |
| result_o | output | ACC_W (40) | Accumulated sum |

## Verification
The bench probes the following corner cases:
- **Pipeline alignment.** Every job is followed cycle by cycle. An off-by-one in the pipeline would move the valid pulse, add a stale tap, or drop the last one.
- **Address wrap.** Base addresses near the top of memory exercise the modulo wrap. A broken wrap would read the wrong operands.
- **Zero taps.** This case catches an engine that reads memory or pulses valid late.
- **Long runs of extreme operands.** These drive the accumulator past both 40-bit limits in each mode. A missing clamp, a clamp in the wrong direction, or a wrongly computed wrap shows up as a wrong result.
- **Start while busy.** A start pulse injected mid-run exposes an engine that restarts or clears its accumulator when it should ignore the pulse.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;

  typedef enum logic {
    ACC_WRAP = 1'b0,
    ACC_SAT  = 1'b1
  } acc_mode_e;

  // tag carried alongside the operand-load stage
  typedef struct packed {
    logic vld;
    logic last;
  } tap_tag_t;

endpackage

// File: rtl/fir_ptr_unit.sv
module fir_ptr_unit #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] ptr_o
);

  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= base_i;
    else if (step_i) ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  // consecutive reads use consecutive addresses, wrapping modulo depth
  p_ptr_advance_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (ptr_o == $past(ptr_o) + 1'b1));

  p_ptr_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ptr_o == $past(base_i)));

endmodule

// File: rtl/fir_tap_ctrl.sv
module fir_tap_ctrl
  import fir_mac_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] taps_i,
  output logic             accept_o,
  output logic             issue_o,
  output tap_tag_t         tag_o,
  output logic             busy_o,
  output logic             valid_o
);

  logic [CNT_W-1:0] cnt_q;
  tap_tag_t         tag_q;
  logic             valid_q;

  assign issue_o  = (cnt_q != '0);
  assign busy_o   = issue_o | tag_q.vld;
  assign accept_o = start_i & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      tag_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (accept_o)     cnt_q <= taps_i;
      else if (issue_o) cnt_q <= cnt_q - 1'b1;
      tag_q.vld  <= issue_o;
      tag_q.last <= issue_o && (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
      valid_q    <= (tag_q.vld & tag_q.last) | (accept_o && (taps_i == '0));
    end
  end

  assign tag_o   = tag_q;
  assign valid_o = valid_q;

  p_ignore_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && issue_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_busy_follows_issue_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |=> busy_o);

  p_valid_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_o);

  p_zero_taps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && (taps_i == '0)) |=> (valid_o && !issue_o));

endmodule

// File: rtl/fir_mac_unit.sv
module fir_mac_unit
  import fir_mac_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ACC_W  = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  acc_mode_e         mode_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [ACC_W-1:0]  acc_o
);

  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod;
  logic [ACC_W:0]           sum;
  logic                     ovf;
  logic [ACC_W-1:0]         acc_d, acc_q;

  assign prod = $signed(a_i) * $signed(b_i);
  assign sum  = {acc_q[ACC_W-1], acc_q} + {{(ACC_W+1-PROD_W){prod[PROD_W-1]}}, prod};
  assign ovf  = sum[ACC_W] ^ sum[ACC_W-1];

  always_comb begin
    acc_d = sum[ACC_W-1:0];
    if (mode_i == ACC_SAT && ovf) acc_d = sum[ACC_W] ? ACC_MIN : ACC_MAX;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  p_clear_on_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_o == '0));

  p_sat_holds_max_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && mode_i == ACC_SAT && acc_q == ACC_MAX && !prod[PROD_W-1])
      |=> (acc_o == ACC_MAX));

  p_sat_holds_min_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && mode_i == ACC_SAT && acc_q == ACC_MIN && (prod[PROD_W-1] || prod == '0))
      |=> (acc_o == ACC_MIN));

endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine
  import fir_mac_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ACC_W    = 40,
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned MAX_TAPS = 1023,
  localparam int unsigned CNT_W   = $clog2(MAX_TAPS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  taps_i,
  input  logic [ADDR_W-1:0] coef_base_i,
  input  logic [ADDR_W-1:0] samp_base_i,
  input  logic              sat_en_i,
  output logic              coef_re_o,
  output logic [ADDR_W-1:0] coef_addr_o,
  input  logic [DATA_W-1:0] coef_rdata_i,
  output logic              samp_re_o,
  output logic [ADDR_W-1:0] samp_addr_o,
  input  logic [DATA_W-1:0] samp_rdata_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [ACC_W-1:0]  result_o
);

  localparam int unsigned N_BANKS = 2;

  logic                     accept, issue;
  tap_tag_t                 tag;
  acc_mode_e                mode_q;
  logic [ADDR_W-1:0]        base [N_BANKS];
  logic [ADDR_W-1:0]        ptr  [N_BANKS];

  assign base[0] = coef_base_i;
  assign base[1] = samp_base_i;

  fir_tap_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .taps_i   (taps_i),
    .accept_o (accept),
    .issue_o  (issue),
    .tag_o    (tag),
    .busy_o   (busy_o),
    .valid_o  (valid_o)
  );

  // one private pointer incrementer per bank
  for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
    fir_ptr_unit #(.ADDR_W(ADDR_W)) u_ptr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (accept),
      .base_i (base[g]),
      .step_i (issue),
      .ptr_o  (ptr[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= ACC_WRAP;
    else if (accept) mode_q <= sat_en_i ? ACC_SAT : ACC_WRAP;
  end

  assign coef_re_o   = issue;
  assign samp_re_o   = issue;
  assign coef_addr_o = ptr[0];
  assign samp_addr_o = ptr[1];

  fir_mac_unit #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .en_i   (tag.vld),
    .mode_i (mode_q),
    .a_i    (coef_rdata_i),
    .b_i    (samp_rdata_i),
    .acc_o  (result_o)
  );

  // both banks address the same tap index
  p_banks_in_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_re_o |-> ((coef_addr_o - coef_base_i) == (samp_addr_o - samp_base_i)) || $past(accept) == 1'b0);

  p_result_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !start_i) |=> $stable(result_o));

endmodule

// File: tb/fir_mac_engine_tb.sv
`timescale 1ns/1ps
module fir_mac_engine_tb_top;

  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [9:0]  taps = '0;
  logic [9:0]  cbase = '0, sbase = '0;
  logic        sat = 1'b0;
  logic        c_re, s_re, busy, valid;
  logic [9:0]  c_addr, s_addr;
  logic [15:0] c_rd, s_rd;
  logic [39:0] result;

  logic [15:0] cmem [DEPTH];
  logic [15:0] smem [DEPTH];

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    if (c_re) c_rd <= cmem[c_addr];
    if (s_re) s_rd <= smem[s_addr];
  end

  fir_mac_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .taps_i(taps),
    .coef_base_i(cbase), .samp_base_i(sbase), .sat_en_i(sat),
    .coef_re_o(c_re), .coef_addr_o(c_addr), .coef_rdata_i(c_rd),
    .samp_re_o(s_re), .samp_addr_o(s_addr), .samp_rdata_i(s_rd),
    .busy_o(busy), .valid_o(valid), .result_o(result)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint model(int n, int cb, int sb, bit sat_m);
    longint acc = 0;
    longint lim_hi = (longint'(1) <<< 39) - 1;
    longint lim_lo = -(longint'(1) <<< 39);
    for (int i = 0; i < n; i++) begin
      longint p = longint'($signed(cmem[(cb + i) % DEPTH])) *
                  longint'($signed(smem[(sb + i) % DEPTH]));
      acc = acc + p;
      if (sat_m) begin
        if (acc > lim_hi) acc = lim_hi;
        if (acc < lim_lo) acc = lim_lo;
      end else begin
        acc = (acc <<< 24) >>> 24;
      end
    end
    return acc;
  endfunction

  task automatic fill_random();
    for (int i = 0; i < DEPTH; i++) begin
      cmem[i] = 16'($urandom);
      smem[i] = 16'($urandom);
    end
  endtask

  task automatic run_job(int n, int cb, int sb, bit sat_m, bit intrude);
    longint exp = model(n, cb, sb, sat_m);
    int lim = (n == 0) ? 2 : n + 3;
    int vcyc = (n == 0) ? 1 : n + 2;
    int re_err = 0, addr_err = 0, busy_err = 0, vld_err = 0;
    @(negedge clk);
    start = 1'b1; taps = 10'(n); cbase = 10'(cb); sbase = 10'(sb); sat = sat_m;
    for (int c = 1; c <= lim; c++) begin
      bit exp_re, exp_busy, exp_vld;
      @(negedge clk);
      exp_re   = (c <= n);
      exp_busy = (n > 0) && (c <= n + 1);
      exp_vld  = (c == vcyc);
      if (c_re !== exp_re || s_re !== exp_re) re_err++;
      if (exp_re && (int'(c_addr) != (cb + c - 1) % DEPTH ||
                     int'(s_addr) != (sb + c - 1) % DEPTH)) addr_err++;
      if (busy !== exp_busy) busy_err++;
      if (valid !== exp_vld) vld_err++;
      if (c == vcyc)
        chk(longint'($signed(result)) == exp, "R2", "sum at valid",
            longint'($signed(result)), exp);
      if (c == vcyc + 1)
        chk(longint'($signed(result)) == exp, "R10", "sum held after valid",
            longint'($signed(result)), exp);
      // drive after sampling
      start = 1'b0;
      if (intrude && c == 2) begin
        start = 1'b1; taps = 10'd7; cbase = 10'd3; sbase = 10'd9; sat = ~sat_m;
      end
    end
    chk(re_err == 0, "R3", "read enables per cycle", re_err, 0);
    chk(addr_err == 0, "R3", "address sequence", addr_err, 0);
    chk(busy_err == 0, intrude ? "R5" : "R5", "busy window", busy_err, 0);
    chk(vld_err == 0, (n == 0) ? "R6" : "R4", "valid timing", vld_err, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    fill_random();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(valid === 1'b0 && busy === 1'b0, "R1", "valid/busy in reset", {valid, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid === 1'b0 && busy === 1'b0 && c_re === 1'b0 && s_re === 1'b0,
        "R1", "control after reset", {valid, busy, c_re, s_re}, 0);
    chk(result === 40'd0, "R1", "result after reset", longint'(result), 0);

    // R2/R4 basic
    run_job(1, 10, 20, 1'b0, 1'b0);
    run_job(5, 100, 300, 1'b1, 1'b0);
    // R6 zero taps, result also cleared (R7)
    run_job(0, 0, 0, 1'b0, 1'b0);
    chk(result === 40'd0, "R7", "cleared by zero-tap start", longint'(result), 0);
    // R3 wrap of both pointers
    run_job(12, 1018, 1020, 1'b0, 1'b0);
    // R5 start while busy ignored
    run_job(9, 40, 60, 1'b0, 1'b1);

    // R8/R9 extreme operands
    for (int i = 0; i < 600; i++) begin cmem[i] = 16'h8000; smem[i] = 16'h8000; end
    run_job(600, 0, 0, 1'b1, 1'b0);
    chk(result == 40'h7F_FFFF_FFFF, "R8", "positive clamp", longint'($signed(result)),
        (longint'(1) <<< 39) - 1);
    run_job(600, 0, 0, 1'b0, 1'b0);
    chk(longint'($signed(result)) == -424 * (longint'(1) <<< 30), "R9", "positive wrap",
        longint'($signed(result)), -424 * (longint'(1) <<< 30));
    for (int i = 0; i < 600; i++) smem[i] = 16'h7FFF;
    run_job(600, 0, 0, 1'b1, 1'b0);
    chk(result == 40'h80_0000_0000, "R8", "negative clamp", longint'($signed(result)),
        -(longint'(1) <<< 39));
    run_job(600, 0, 0, 1'b0, 1'b0);
    // R7 small job after a clamped one starts from zero
    cmem[700] = 16'd3; smem[800] = 16'hFFFE;
    run_job(1, 700, 800, 1'b1, 1'b0);
    chk(longint'($signed(result)) == -6, "R7", "no carry-over", longint'($signed(result)), -6);

    // random mix
    fill_random();
    for (int j = 0; j < 40; j++) begin
      int n = $urandom_range(0, 40);
      run_job(n, $urandom_range(0, DEPTH - 1), $urandom_range(0, DEPTH - 1),
              1'($urandom), (n >= 3) && ($urandom_range(0, 3) == 0));
    end
    run_job(1023, 5, 17, 1'b0, 1'b0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule